// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a memory-mapped real-time clock. It holds the time of day (hours, minutes, seconds) and a calendar date (day, month, four-digit year) as packed BCD words. A one-cycle pulse on `sec_tick`, arriving once per second, advances the clock by one second. The pulse is already synchronous to `clk`. Software reads and writes six 32-bit word registers through a simple bus with address, write enable, write data and combinational read data.

Writes to the time word and the date word do not take effect at once. This models the crossing into the slow timekeeping domain. Each of the two words has its own transfer state machine with two states. `XF_IDLE` moves to `XF_HOLD` when a write is accepted. `XF_HOLD` moves back to `XF_IDLE` on the commit tick, which is the `COMMIT_TICKS`-th tick after the write. A write that arrives while its word is in `XF_HOLD` takes the drop transition: it stays in `XF_HOLD` and marks the write as lost. The alarm time and alarm date words are compared with the clock on every tick. A match sets a sticky flag, and the flag drives `alarm_irq` when the enable bit is set. Control bit 9 is a debug bypass: while it is set, reads of the date address return the time word.

Register word index (byte offset / 4): 0 time, 1 date, 2 alarm time, 3 alarm date, 4 control, 5 status.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read as follows: time 0x00000000, date 0x20000101 (2000-01-01), alarm words 0, control 0 and status 0 (with `osc_ok` high). `alarm_irq` is low.
- R2: Only defined bits are kept, so read-back is masked. Time and alarm-time words keep 0x003F7F7F: seconds in 6:0, minutes in 14:8, hours in 21:16. Date and alarm-date words keep 0xFFFF1F3F: day in 5:0, month in 12:8, year in 31:16. Control keeps 0x80000200. An access whose byte address is not a multiple of four, or whose word index is above 5, writes nothing and reads 0.
- R3: A write to time or date sets status bit 2 (time) or bit 3 (date). The written value replaces the clock word on the `COMMIT_TICKS`-th tick after the write (default 2), and the pending bit clears in that same cycle. Until then the clock keeps counting from its old value.
- R4: A write to time or date while its pending bit is set is dropped. It sets status bit 4 (time) or bit 5 (date). That bit stays set until status is written with a 1 in that position.
- R5: On each tick the seconds count up in BCD. Seconds and minutes roll over after 59 and hours roll over after 23, each carrying into the next field.
- R6: A carry out of the hours advances the day. The day returns to 01 after 31, 30 or 28 according to the month, with February always 28, and the month then advances.
- R7: The month returns to 01 after 12 and carries into a four-digit BCD year. The year wraps from 9999 to 0000.
- R8: Status bit 31 is set on a tick after which time and date equal the alarm words. Writing status with bit 31 set clears it.
- R9: `alarm_irq` is high exactly when status bit 31 and control bit 31 are both set.
- R10: While control bit 9 is set, a read of the date address returns the time word.
- R11: Status bit 0 reads as the inverse of `osc_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| osc_ok | input | 1 | High while the timekeeping clock is connected |
| bus_addr | input | ADDR_W (5) | Byte address of the word register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The bench goes after the calendar carries with the most reach. These are 23:59:59 at the end of months of 28, 30 and 31 days, the year-end carry into the tens of years, and the 9999-to-0000 wrap. A design with a wrong day limit would show 02-29 or 04-31, and a broken carry chain would leave the date unchanged. It checks that a write is held for exactly the commit window: an early commit shows the new time after one tick, and a late one shows the counted-up old time. A second write during the hold must be dropped and flagged. A design that overwrote the staged value, or cleared the lost bit on commit, would read back the second value or a zero lost bit. It also covers the alarm flag staying set while the interrupt is masked, its write-one clear, and the date bypass, where a wrong decode would return the date.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_REGS   = 6;
    localparam int NUM_CHAN   = 2;

    localparam logic [2:0] IDX_TIME  = 3'd0;
    localparam logic [2:0] IDX_DATE  = 3'd1;
    localparam logic [2:0] IDX_ATIME = 3'd2;
    localparam logic [2:0] IDX_ADATE = 3'd3;
    localparam logic [2:0] IDX_CTRL  = 3'd4;
    localparam logic [2:0] IDX_STAT  = 3'd5;

    localparam logic [WORD_W-1:0] TIME_MASK  = 32'h003F_7F7F;
    localparam logic [WORD_W-1:0] DATE_MASK  = 32'hFFFF_1F3F;
    localparam logic [WORD_W-1:0] CTRL_MASK  = 32'h8000_0200;
    localparam logic [WORD_W-1:0] DATE_RESET = 32'h2000_0101;

    localparam int CTRL_EN_BIT  = 31;
    localparam int CTRL_BYP_BIT = 9;
    localparam int ST_FLAG_BIT  = 31;
    localparam int ST_LOST_LO   = 4;

    typedef enum logic {
        XF_IDLE,
        XF_HOLD
    } xfer_state_e;

    // Unpacked calendar fields, each padded to whole BCD bytes
    typedef struct packed {
        logic [15:0] yr;
        logic [7:0]  mon;
        logic [7:0]  day;
        logic [7:0]  hr;
        logic [7:0]  mn;
        logic [7:0]  sc;
    } cal_t;

    // Two-digit BCD step: returns {carry, next value}
    function automatic logic [8:0] bcd2_step(input logic [7:0] v,
                                             input logic [7:0] last,
                                             input logic [7:0] first);
        if (v == last)
            return {1'b1, first};
        else if (v[3:0] == 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last BCD day of a BCD month, February fixed at 28
    function automatic logic [7:0] month_last_day(input logic [7:0] mon);
        case (mon)
            8'h02:                      return 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
    import rtc_pkg::*;
#(
    parameter int YEAR_DIGITS = 4
) (
    input  cal_t cur,
    output cal_t nxt
);
    localparam int YR_W = 4 * YEAR_DIGITS;

    logic [8:0]      s_step, m_step, h_step, d_step, mo_step;
    logic [YR_W-1:0] yr_next;
    logic            yr_carry;

    always_comb begin
        s_step  = bcd2_step(cur.sc, 8'h59, 8'h00);
        m_step  = s_step[8] ? bcd2_step(cur.mn, 8'h59, 8'h00) : {1'b0, cur.mn};
        h_step  = m_step[8] ? bcd2_step(cur.hr, 8'h23, 8'h00) : {1'b0, cur.hr};
        d_step  = h_step[8] ? bcd2_step(cur.day, month_last_day(cur.mon), 8'h01)
                            : {1'b0, cur.day};
        mo_step = d_step[8] ? bcd2_step(cur.mon, 8'h12, 8'h01) : {1'b0, cur.mon};

        yr_carry = mo_step[8];
        yr_next  = cur.yr[YR_W-1:0];
        for (int i = 0; i < YEAR_DIGITS; i++) begin
            if (yr_carry) begin
                if (yr_next[i*4 +: 4] == 4'd9) begin
                    yr_next[i*4 +: 4] = 4'd0;
                end else begin
                    yr_next[i*4 +: 4] = yr_next[i*4 +: 4] + 4'd1;
                    yr_carry = 1'b0;
                end
            end
        end

        nxt.sc  = s_step[7:0];
        nxt.mn  = m_step[7:0];
        nxt.hr  = h_step[7:0];
        nxt.day = d_step[7:0];
        nxt.mon = mo_step[7:0];
        nxt.yr  = yr_next;
    end
endmodule

// File: rtl/rtc_write_xfer.sv
module rtc_write_xfer
    import rtc_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter int COMMIT_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             lost_clr,
    output logic             pending,
    output logic             commit,
    output logic             lost,
    output logic [WIDTH-1:0] staged
);
    localparam int CNT_W = (COMMIT_TICKS < 2) ? 1 : $clog2(COMMIT_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COMMIT_TICKS - 1);

    xfer_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;
    logic             drop;

    assign last_tick = tick && (cnt_q == CNT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: if (wr_req)    state_d = XF_HOLD;
            XF_HOLD: if (last_tick) state_d = XF_IDLE;
            default:                state_d = XF_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pending = 1'b0;
        commit  = 1'b0;
        drop    = 1'b0;
        unique case (state_q)
            XF_IDLE: ;
            XF_HOLD: begin
                pending = 1'b1;
                commit  = last_tick;
                drop    = wr_req;
            end
            default: ;
        endcase
    end

    // Staged word and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged <= '0;
            cnt_q  <= '0;
        end else if (state_q == XF_IDLE && wr_req) begin
            staged <= wr_data;
            cnt_q  <= '0;
        end else if (state_q == XF_HOLD && tick && !last_tick) begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    // Sticky lost-write flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        lost <= 1'b0;
        else if (drop)     lost <= 1'b1;
        else if (lost_clr) lost <= 1'b0;
    end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W       = 5,
    parameter int COMMIT_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              osc_ok,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              alarm_irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic [2:0]       sel;
    logic             aligned;
    logic [NUM_REGS-1:0] wr_hit;

    logic [WORD_W-1:0] time_q, date_q, alm_t_q, alm_d_q, ctrl_q;
    logic              alarm_flag;

    logic [NUM_CHAN-1:0] pend, lost, commit, ch_wr, ch_lost_clr;
    logic [WORD_W-1:0]   ch_wdata [NUM_CHAN];
    logic [WORD_W-1:0]   ch_staged[NUM_CHAN];

    cal_t              cal_cur, cal_nxt;
    logic [WORD_W-1:0] adv_time, adv_date, new_time, new_date;
    logic              alarm_hit;

    // Address decode
    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00) && (int'(widx) < NUM_REGS);
    assign sel     = 3'(widx);

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++)
            wr_hit[i] = bus_we && aligned && (sel == 3'(i));
    end

    // Per-channel write transfer (0: time, 1: date)
    assign ch_wr[0]       = wr_hit[IDX_TIME];
    assign ch_wr[1]       = wr_hit[IDX_DATE];
    assign ch_wdata[0]    = bus_wdata & TIME_MASK;
    assign ch_wdata[1]    = bus_wdata & DATE_MASK;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_xfer
        assign ch_lost_clr[c] = wr_hit[IDX_STAT] && bus_wdata[ST_LOST_LO + c];

        rtc_write_xfer #(
            .WIDTH        (WORD_W),
            .COMMIT_TICKS (COMMIT_TICKS)
        ) u_xfer (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (sec_tick),
            .wr_req   (ch_wr[c]),
            .wr_data  (ch_wdata[c]),
            .lost_clr (ch_lost_clr[c]),
            .pending  (pend[c]),
            .commit   (commit[c]),
            .lost     (lost[c]),
            .staged   (ch_staged[c])
        );
    end

    // Calendar advance
    assign cal_cur = '{
        yr:  date_q[31:16],
        mon: {3'b000, date_q[12:8]},
        day: {2'b00,  date_q[5:0]},
        hr:  {2'b00,  time_q[21:16]},
        mn:  {1'b0,   time_q[14:8]},
        sc:  {1'b0,   time_q[6:0]}
    };

    rtc_calendar_step #(.YEAR_DIGITS(4)) u_step (
        .cur (cal_cur),
        .nxt (cal_nxt)
    );

    assign adv_time = {8'h00, cal_nxt.hr, cal_nxt.mn, cal_nxt.sc} & TIME_MASK;
    assign adv_date = {cal_nxt.yr, cal_nxt.mon, cal_nxt.day} & DATE_MASK;
    assign new_time = commit[0] ? ch_staged[0] : adv_time;
    assign new_date = commit[1] ? ch_staged[1] : adv_date;
    assign alarm_hit = (new_time == alm_t_q) && (new_date == alm_d_q);

    // Timekeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
            date_q <= DATE_RESET;
        end else if (sec_tick) begin
            time_q <= new_time;
            date_q <= new_date;
        end
    end

    // Alarm and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_t_q <= '0;
            alm_d_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (wr_hit[IDX_ATIME]) alm_t_q <= bus_wdata & TIME_MASK;
            if (wr_hit[IDX_ADATE]) alm_d_q <= bus_wdata & DATE_MASK;
            if (wr_hit[IDX_CTRL])  ctrl_q  <= bus_wdata & CTRL_MASK;
        end
    end

    // Alarm flag: set on match, write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            alarm_flag <= 1'b0;
        else if (sec_tick && alarm_hit)
            alarm_flag <= 1'b1;
        else if (wr_hit[IDX_STAT] && bus_wdata[ST_FLAG_BIT])
            alarm_flag <= 1'b0;
    end

    assign alarm_irq = alarm_flag & ctrl_q[CTRL_EN_BIT];

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (sel)
                IDX_TIME:  bus_rdata = time_q;
                IDX_DATE:  bus_rdata = ctrl_q[CTRL_BYP_BIT] ? time_q : date_q;
                IDX_ATIME: bus_rdata = alm_t_q;
                IDX_ADATE: bus_rdata = alm_d_q;
                IDX_CTRL:  bus_rdata = ctrl_q;
                IDX_STAT:  bus_rdata = {alarm_flag, 25'd0, lost[1], lost[0],
                                        pend[1], pend[0], 1'b0, ~osc_ok};
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              alarm_irq,
    input logic [31:0]       time_q,
    input logic [1:0]        pend,
    input logic [1:0]        lost,
    input logic              flag,
    input logic              ctrl_en
);
    // R4
    lost_time_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost[0]) |-> $past(bus_we && bus_addr == ADDR_W'(0)));

    // R4
    lost_date_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost[1]) |-> $past(bus_we && bus_addr == ADDR_W'(4)));

    // R3
    pend_rise_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[0]) |-> $past(bus_we && bus_addr == ADDR_W'(0)));

    // R3
    pend_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pend[0]) || $fell(pend[1])) |-> $past(sec_tick));

    // R5
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sec_tick) |-> $stable(time_q));

    // R8
    flag_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(sec_tick));

    // R9
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (ctrl_en && flag));
endmodule

bind bcd_rtc rtc_checker #(.ADDR_W(ADDR_W)) u_rtc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .alarm_irq (alarm_irq),
    .time_q    (time_q),
    .pend      (pend),
    .lost      (lost),
    .flag      (alarm_flag),
    .ctrl_en   (ctrl_q[31])
);

// File: tb/bcd_rtc_test.sv
`timescale 1ns/1ps
module bcd_rtc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        osc_ok = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bcd_rtc #(.ADDR_W(5), .COMMIT_TICKS(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .osc_ok    (osc_ok),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    // {start time, start date, time after one tick, date after one tick}
    localparam int NV = 11;
    localparam logic [127:0] VECS [NV] = '{
        {32'h00000059, 32'h20240115, 32'h00000100, 32'h20240115},
        {32'h00125959, 32'h20240115, 32'h00130000, 32'h20240115},
        {32'h00195959, 32'h20230704, 32'h00200000, 32'h20230704},
        {32'h00090909, 32'h20230629, 32'h00090910, 32'h20230629},
        {32'h00235959, 32'h20230131, 32'h00000000, 32'h20230201},
        {32'h00235959, 32'h20230228, 32'h00000000, 32'h20230301},
        {32'h00235959, 32'h20230430, 32'h00000000, 32'h20230501},
        {32'h00235959, 32'h20230330, 32'h00000000, 32'h20230331},
        {32'h00235959, 32'h20231231, 32'h00000000, 32'h20240101},
        {32'h00235959, 32'h99991231, 32'h00000000, 32'h00000101},
        {32'h00235959, 32'h20191231, 32'h00000000, 32'h20200101}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic set_clock(input logic [31:0] t, input logic [31:0] d);
        bus_write(5'h00, t);
        bus_write(5'h04, d);
        tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] tnow;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(5'h00, rd); check("R1 time", rd, 32'h0);
        bus_read(5'h04, rd); check("R1 date", rd, 32'h20000101);
        bus_read(5'h08, rd); check("R1 alarm time", rd, 32'h0);
        bus_read(5'h0C, rd); check("R1 alarm date", rd, 32'h0);
        bus_read(5'h10, rd); check("R1 ctrl", rd, 32'h0);
        bus_read(5'h14, rd); check("R1 status", rd, 32'h0);
        check("R1 irq", {31'd0, alarm_irq}, 32'd0);

        // R11 clock-missing status
        osc_ok = 1'b0;
        bus_read(5'h14, rd); check("R11 osc lost", rd, 32'h1);
        osc_ok = 1'b1;
        bus_read(5'h14, rd); check("R11 osc ok", rd, 32'h0);

        // R2 masking and decode
        bus_write(5'h08, 32'hFFFFFFFF);
        bus_read(5'h08, rd); check("R2 alarm time mask", rd, 32'h003F7F7F);
        bus_write(5'h0C, 32'hFFFFFFFF);
        bus_read(5'h0C, rd); check("R2 alarm date mask", rd, 32'hFFFF1F3F);
        bus_write(5'h10, 32'hFFFFFFFF);
        bus_read(5'h10, rd); check("R2 ctrl mask", rd, 32'h80000200);
        bus_write(5'h10, 32'h0);
        bus_write(5'h09, 32'h0);
        bus_read(5'h08, rd); check("R2 misaligned write ignored", rd, 32'h003F7F7F);
        bus_read(5'h18, rd); check("R2 unmapped read", rd, 32'h0);
        bus_write(5'h08, 32'h0);
        bus_write(5'h0C, 32'h0);

        // R3 pending window
        bus_write(5'h00, 32'h00123456);
        bus_read(5'h14, rd); check("R3 pending set", rd, 32'h4);
        tick();
        bus_read(5'h00, rd); check("R3 old time still counting", rd, 32'h00000001);
        bus_read(5'h14, rd); check("R3 pending held", rd, 32'h4);
        tick();
        bus_read(5'h00, rd); check("R3 committed", rd, 32'h00123456);
        bus_read(5'h14, rd); check("R3 pending cleared", rd, 32'h0);

        // R4 lost writes
        bus_write(5'h00, 32'h00010203);
        bus_write(5'h00, 32'h00020000);
        bus_read(5'h14, rd); check("R4 time lost+pend", rd, 32'h14);
        tick(); tick();
        bus_read(5'h00, rd); check("R4 first write kept", rd, 32'h00010203);
        bus_read(5'h14, rd); check("R4 lost sticky", rd, 32'h10);
        bus_write(5'h14, 32'h10);
        bus_read(5'h14, rd); check("R4 lost cleared", rd, 32'h0);
        bus_write(5'h04, 32'h20240301);
        bus_write(5'h04, 32'h20250101);
        bus_read(5'h14, rd); check("R4 date lost+pend", rd, 32'h28);
        tick(); tick();
        bus_read(5'h04, rd); check("R4 first date kept", rd, 32'h20240301);
        bus_write(5'h14, 32'h20);
        bus_read(5'h14, rd); check("R4 date lost cleared", rd, 32'h0);

        // R5 R6 R7 table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = (i < 4) ? "R5" : (i < 8) ? "R6" : "R7";
            set_clock(VECS[i][127:96], VECS[i][95:64]);
            bus_read(5'h00, rd); check("R3 vector commit time", rd, VECS[i][127:96]);
            bus_read(5'h04, rd); check("R3 vector commit date", rd, VECS[i][95:64]);
            tick();
            bus_read(5'h00, rd); check({tag, " time step"}, rd, VECS[i][63:32]);
            bus_read(5'h04, rd); check({tag, " date step"}, rd, VECS[i][31:0]);
        end

        // R8 R9 alarm
        set_clock(32'h00100000, 32'h20240505);
        bus_write(5'h08, 32'h00100002);
        bus_write(5'h0C, 32'h20240505);
        bus_write(5'h10, 32'h80000000);
        tick();
        bus_read(5'h14, rd); check("R8 no early flag", rd, 32'h0);
        check("R9 irq low before match", {31'd0, alarm_irq}, 32'd0);
        tick();
        bus_read(5'h14, rd); check("R8 flag on match", rd, 32'h80000000);
        check("R9 irq high", {31'd0, alarm_irq}, 32'd1);
        bus_write(5'h10, 32'h0);
        check("R9 irq masked", {31'd0, alarm_irq}, 32'd0);
        bus_read(5'h14, rd); check("R8 flag kept while masked", rd, 32'h80000000);
        bus_write(5'h14, 32'h80000000);
        bus_read(5'h14, rd); check("R8 flag cleared", rd, 32'h0);
        bus_write(5'h10, 32'h80000000);
        check("R9 irq low after clear", {31'd0, alarm_irq}, 32'd0);
        bus_write(5'h10, 32'h0);

        // R10 bypass
        bus_write(5'h10, 32'h00000200);
        bus_read(5'h00, tnow);
        bus_read(5'h04, rd); check("R10 date mirrors time", rd, tnow);
        bus_write(5'h10, 32'h0);
        bus_read(5'h04, rd); check("R10 date restored", rd, 32'h20240505);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule